// File: doc/BRIEF.md
# Precise exception pipeline controller

This block follows every instruction of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and makes sure that faults are handled precisely. Each slot in the pipeline holds a valid bit, the instruction's own PC and a cause code. A stage that detects a fault marks the cause on the instruction it holds. The controller acts on a fault only when that instruction reaches writeback. At that point it captures the faulting PC and the cause, redirects fetch to a fixed handler address, and clears the valid bits of every younger slot. No younger instruction retires or stores. An external interrupt enters the pipe as a bubble that already carries a fault. It takes the fetch slot and the PC of the instruction it displaces, so the handler can return to that instruction.

Instructions enter over a valid/ready handshake. The producer presents `fetch_valid_i` with `fetch_pc_i` and must hold both unchanged until it sees `fetch_ready_o` high at a clock edge. Ready drops in two cases: in the cycle an interrupt is injected, and in the cycle a trap is taken. Writeback has no back-pressure; the pipe advances every cycle. The per-stage fault inputs and the interrupt line are plain control pins.

Top module: `exc_pipe_ctl`

## Requirements
- R1: While reset is held and just after it is released, the pipe is empty. `fetch_ready_o` is 1. `retire_valid_o`, `trap_o` and `mem_store_ok_o` are 0. `epc_o` and `cause_o` are 0.
- R2: An instruction accepted in cycle n with no fault retires in cycle n+5. `retire_valid_o` is 1 and `retire_pc_o` equals its PC. Retirement is in acceptance order.
- R3: Cause codes are 3 bits: 0 none, 1 fetch fault (`fault_i[0]`), 2 illegal opcode (`fault_i[1]`), 3 arithmetic overflow (`fault_i[2]`), 4 data memory fault (`fault_i[3]`), 5 interrupt. A fault input applies to the instruction in that stage during that cycle. An instruction that faults in stage s in cycle c raises `trap_o` in cycle c + 4 − s, with `trap_cause_o` set to its code.
- R4: When one instruction is faulted in more than one stage, the code from the earliest stage is kept.
- R5: When an older instruction faults in a later stage and a younger one faults in an earlier stage, only the older fault traps.
- R6: In the cycle after `trap_o`, `epc_o` holds the trapping PC and `cause_o` holds its code. Both stay unchanged until the next trap. `trap_vec_o` equals the handler address parameter.
- R7: The trapping instruction and all instructions younger than it never retire.
- R8: When `irq_i` is high, `fetch_ready_o` is 0. A faulting no-op with cause 5 and PC `fetch_pc_i` enters fetch, and it traps five cycles later.
- R9: `fetch_ready_o` is 0 in every cycle that `trap_o` is 1.
- R10: `mem_store_ok_o` is 1 only when the memory stage holds a valid instruction that carries no cause, `fault_i[3]` is low, and no trap is being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch slot offered |
| fetch_pc_i | input | PC_W | PC of the offered instruction |
| fetch_ready_o | output | 1 | Offered instruction accepted at this edge |
| irq_i | input | 1 | External interrupt request |
| fault_i | input | 4 | Fault flags of fetch, decode, execute, memory (bits 0..3) |
| retire_valid_o | output | 1 | Writeback instruction commits its register write |
| retire_pc_o | output | PC_W | PC of the retiring instruction |
| mem_store_ok_o | output | 1 | Memory stage may perform its store |
| trap_o | output | 1 | A fault is being taken this cycle |
| trap_cause_o | output | 3 | Cause of the trapping instruction |
| trap_vec_o | output | PC_W | Handler address for fetch redirection |
| epc_o | output | PC_W | Saved PC of the last trapping instruction |
| cause_o | output | 3 | Saved cause of the last trap |

## Verification
Combinational outputs follow the writeback or memory slot in the same cycle. Retirement and traps therefore appear exactly five cycles after the instruction was offered, or 4 − s cycles after a fault in stage s. The saved PC and cause appear one cycle after the trap. The bench drives its inputs on the falling edge and samples 1 ns later, still before the next rising edge. It logs the cycle of each trap and compares that cycle with the cycle worked out in the vector table. It reads the saved registers only after the run has settled.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NUM_STAGES  = 5;
  localparam int NUM_FAULTED = NUM_STAGES - 1;
  localparam int CAUSE_W     = 3;
  localparam int WB_IDX      = NUM_STAGES - 1;
  localparam int MEM_IDX     = NUM_STAGES - 2;

  typedef enum logic [CAUSE_W-1:0] {
    CS_NONE    = 3'd0,
    CS_FETCH   = 3'd1,
    CS_ILLEGAL = 3'd2,
    CS_OVF     = 3'd3,
    CS_DMEM    = 3'd4,
    CS_IRQ     = 3'd5
  } exc_cause_e;

  // Code reported by each faulting stage, youngest stage first.
  function automatic exc_cause_e stage_code(input int idx);
    case (idx)
      0:       return CS_FETCH;
      1:       return CS_ILLEGAL;
      2:       return CS_OVF;
      default: return CS_DMEM;
    endcase
  endfunction

endpackage

// File: rtl/exc_fault_fold.sv
module exc_fault_fold
  import exc_pkg::*;
#(
  parameter exc_cause_e CODE = CS_FETCH
) (
  input  logic       valid_i,
  input  exc_cause_e cause_i,
  input  logic       flt_i,
  output exc_cause_e cause_o
);

  // The first recorded cause sticks; a later stage cannot overwrite it.
  always_comb begin
    cause_o = cause_i;
    if (valid_i && (cause_i == CS_NONE) && flt_i) begin
      cause_o = CODE;
    end
  end

endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic            d_valid_i,
  input  logic [PC_W-1:0] d_pc_i,
  input  exc_cause_e      d_cause_i,
  output logic            q_valid_o,
  output logic [PC_W-1:0] q_pc_o,
  output exc_cause_e      q_cause_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid_o <= 1'b0;
      q_pc_o    <= '0;
      q_cause_o <= CS_NONE;
    end else begin
      q_valid_o <= d_valid_i && !flush_i;
      q_pc_o    <= d_pc_i;
      q_cause_o <= flush_i ? CS_NONE : d_cause_i;
    end
  end

endmodule

// File: rtl/exc_trap_unit.sv
module exc_trap_unit
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wb_valid_i,
  input  logic [PC_W-1:0] wb_pc_i,
  input  exc_cause_e      wb_cause_i,
  output logic            trap_o,
  output logic            commit_o,
  output logic [PC_W-1:0] epc_o,
  output exc_cause_e      cause_o
);

  assign trap_o   = wb_valid_i && (wb_cause_i != CS_NONE);
  assign commit_o = wb_valid_i && (wb_cause_i == CS_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_o   <= '0;
      cause_o <= CS_NONE;
    end else if (trap_o) begin
      epc_o   <= wb_pc_i;
      cause_o <= wb_cause_i;
    end
  end

endmodule

// File: rtl/exc_pipe_ctl.sv
module exc_pipe_ctl
  import exc_pkg::*;
#(
  parameter int              PC_W    = 32,
  parameter logic [PC_W-1:0] VEC_ADDR = 32'h0000_0080
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid_i,
  input  logic [PC_W-1:0]        fetch_pc_i,
  output logic                   fetch_ready_o,
  input  logic                   irq_i,
  input  logic [NUM_FAULTED-1:0] fault_i,
  output logic                   retire_valid_o,
  output logic [PC_W-1:0]        retire_pc_o,
  output logic                   mem_store_ok_o,
  output logic                   trap_o,
  output logic [CAUSE_W-1:0]     trap_cause_o,
  output logic [PC_W-1:0]        trap_vec_o,
  output logic [PC_W-1:0]        epc_o,
  output logic [CAUSE_W-1:0]     cause_o
);

  logic            st_valid [NUM_STAGES];
  logic [PC_W-1:0] st_pc    [NUM_STAGES];
  exc_cause_e      st_cause [NUM_STAGES];

  logic            nx_valid [NUM_STAGES];
  logic [PC_W-1:0] nx_pc    [NUM_STAGES];
  exc_cause_e      nx_cause [NUM_STAGES];

  logic       taking;
  logic       inject;
  logic       accept;
  exc_cause_e saved_cause;

  // Fetch entry: an interrupt displaces the offered instruction.
  assign inject        = irq_i && !taking;
  assign fetch_ready_o = !irq_i && !taking;
  assign accept        = fetch_valid_i && fetch_ready_o;

  assign nx_valid[0] = inject || accept;
  assign nx_pc[0]    = fetch_pc_i;
  assign nx_cause[0] = inject ? CS_IRQ : CS_NONE;

  genvar k;
  generate
    for (k = 1; k < NUM_STAGES; k++) begin : g_fold
      assign nx_valid[k] = st_valid[k-1];
      assign nx_pc[k]    = st_pc[k-1];
      exc_fault_fold #(
        .CODE (stage_code(k-1))
      ) u_fold (
        .valid_i (st_valid[k-1]),
        .cause_i (st_cause[k-1]),
        .flt_i   (fault_i[k-1]),
        .cause_o (nx_cause[k])
      );
    end

    for (k = 0; k < NUM_STAGES; k++) begin : g_stage
      exc_stage_reg #(
        .PC_W (PC_W)
      ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (taking),
        .d_valid_i (nx_valid[k]),
        .d_pc_i    (nx_pc[k]),
        .d_cause_i (nx_cause[k]),
        .q_valid_o (st_valid[k]),
        .q_pc_o    (st_pc[k]),
        .q_cause_o (st_cause[k])
      );
    end
  endgenerate

  exc_trap_unit #(
    .PC_W (PC_W)
  ) u_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_valid_i (st_valid[WB_IDX]),
    .wb_pc_i    (st_pc[WB_IDX]),
    .wb_cause_i (st_cause[WB_IDX]),
    .trap_o     (taking),
    .commit_o   (retire_valid_o),
    .epc_o      (epc_o),
    .cause_o    (saved_cause)
  );

  assign retire_pc_o    = st_pc[WB_IDX];
  assign trap_o         = taking;
  assign trap_cause_o   = st_cause[WB_IDX];
  assign trap_vec_o     = VEC_ADDR;
  assign cause_o        = saved_cause;
  assign mem_store_ok_o = st_valid[MEM_IDX] && (st_cause[MEM_IDX] == CS_NONE)
                          && !fault_i[MEM_IDX] && !taking;

endmodule

// File: rtl/exc_pipe_ctl_chk.sv
module exc_pipe_ctl_chk
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fetch_ready_o,
  input logic                   irq_i,
  input logic                   retire_valid_o,
  input logic                   mem_store_ok_o,
  input logic                   trap_o,
  input logic [CAUSE_W-1:0]     trap_cause_o,
  input logic [PC_W-1:0]        retire_pc_o,
  input logic [PC_W-1:0]        epc_o,
  input logic [CAUSE_W-1:0]     cause_o
);

  // R6
  epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (epc_o == $past(retire_pc_o)) && (cause_o == $past(trap_cause_o)));

  // R6
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |=> $stable(epc_o) && $stable(cause_o));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> !retire_valid_o && !trap_o);

  // R9
  trap_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !fetch_ready_o);

  // R8
  irq_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |-> !fetch_ready_o);

  // R10
  store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !mem_store_ok_o);

endmodule

bind exc_pipe_ctl exc_pipe_ctl_chk #(
  .PC_W (PC_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_ready_o  (fetch_ready_o),
  .irq_i          (irq_i),
  .retire_valid_o (retire_valid_o),
  .mem_store_ok_o (mem_store_ok_o),
  .trap_o         (trap_o),
  .trap_cause_o   (trap_cause_o),
  .retire_pc_o    (retire_pc_o),
  .epc_o          (epc_o),
  .cause_o        (cause_o)
);

// File: tb/exc_pipe_ctl_bench.sv
module exc_pipe_ctl_bench;

  localparam int          PC_W  = 32;
  localparam logic [31:0] VEC   = 32'h0000_0080;
  localparam logic [31:0] BASE  = 32'h0000_1000;
  localparam int          NCYC  = 16;
  localparam int          NINS  = 8;
  localparam int          NV    = 10;

  typedef struct packed {
    logic [2:0]  fa_st;
    logic [4:0]  fa_cy;
    logic [2:0]  fb_st;
    logic [4:0]  fb_cy;
    logic [4:0]  irq_cy;
    logic [4:0]  trap_cy;
    logic [15:0] epc;
    logic [2:0]  cause;
    logic [3:0]  ret;
  } vec_t;

  // stage 7 / cycle 31 mean "none"
  localparam vec_t VECS [NV] = '{
    '{3'd7, 5'd0,  3'd7, 5'd0, 5'd31, 5'd31, 16'h0000, 3'd0, 4'd8},
    '{3'd0, 5'd3,  3'd7, 5'd0, 5'd31, 5'd7,  16'h1008, 3'd1, 4'd2},
    '{3'd1, 5'd5,  3'd7, 5'd0, 5'd31, 5'd8,  16'h100C, 3'd2, 4'd3},
    '{3'd2, 5'd4,  3'd7, 5'd0, 5'd31, 5'd6,  16'h1004, 3'd3, 4'd1},
    '{3'd3, 5'd4,  3'd7, 5'd0, 5'd31, 5'd5,  16'h1000, 3'd4, 4'd0},
    '{3'd3, 5'd6,  3'd0, 5'd5, 5'd31, 5'd7,  16'h1008, 3'd4, 4'd2},
    '{3'd1, 5'd3,  3'd2, 5'd4, 5'd31, 5'd6,  16'h1004, 3'd2, 4'd1},
    '{3'd7, 5'd0,  3'd7, 5'd0, 5'd3,  5'd8,  16'h100C, 3'd5, 4'd3},
    '{3'd2, 5'd4,  3'd7, 5'd0, 5'd2,  5'd6,  16'h1004, 3'd3, 4'd1},
    '{3'd3, 5'd11, 3'd7, 5'd0, 5'd31, 5'd12, 16'h101C, 3'd4, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        fetch_ready_o;
  logic        irq_i = 1'b0;
  logic [3:0]  fault_i = '0;
  logic        retire_valid_o;
  logic [31:0] retire_pc_o;
  logic        mem_store_ok_o;
  logic        trap_o;
  logic [2:0]  trap_cause_o;
  logic [31:0] trap_vec_o;
  logic [31:0] epc_o;
  logic [2:0]  cause_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_pipe_ctl #(.PC_W(PC_W), .VEC_ADDR(VEC)) u_exc_pipe_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid_i  (fetch_valid_i),
    .fetch_pc_i     (fetch_pc_i),
    .fetch_ready_o  (fetch_ready_o),
    .irq_i          (irq_i),
    .fault_i        (fault_i),
    .retire_valid_o (retire_valid_o),
    .retire_pc_o    (retire_pc_o),
    .mem_store_ok_o (mem_store_ok_o),
    .trap_o         (trap_o),
    .trap_cause_o   (trap_cause_o),
    .trap_vec_o     (trap_vec_o),
    .epc_o          (epc_o),
    .cause_o        (cause_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fetch_valid_i = 1'b0;
    fetch_pc_i = '0;
    irq_i = 1'b0;
    fault_i = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk("R1 ready", {31'd0, fetch_ready_o}, 32'd1);
    chk("R1 retire", {31'd0, retire_valid_o}, 32'd0);
    chk("R1 trap", {31'd0, trap_o}, 32'd0);
    chk("R1 store", {31'd0, mem_store_ok_o}, 32'd0);
    chk("R1 epc", epc_o, 32'd0);
    chk("R1 cause", {29'd0, cause_o}, 32'd0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      int issued;
      int nret;
      int tcyc;
      logic [2:0] tcause;
      logic [31:0] tpc;
      bit trapped;
      vec_t cv;
      cv = VECS[v];
      issued = 0; nret = 0; tcyc = 31; tcause = '0; tpc = '0; trapped = 1'b0;
      do_reset();
      for (int n = 0; n < NCYC; n++) begin
        fetch_valid_i = (issued < NINS) && !trapped;
        fetch_pc_i = BASE + 32'(4 * issued);
        irq_i = (n == int'(cv.irq_cy));
        fault_i = '0;
        if (cv.fa_st != 3'd7 && n == int'(cv.fa_cy)) fault_i[int'(cv.fa_st)] = 1'b1;
        if (cv.fb_st != 3'd7 && n == int'(cv.fb_cy)) fault_i[int'(cv.fb_st)] = 1'b1;
        #1;
        if (irq_i) chk($sformatf("R8 v%0d irq holds fetch", v), {31'd0, fetch_ready_o}, 32'd0);
        if (retire_valid_o) begin
          // R2 in-order retirement PCs
          chk($sformatf("R2 v%0d retire pc", v), retire_pc_o, BASE + 32'(4 * nret));
          nret++;
        end
        if (trap_o && !trapped) begin
          trapped = 1'b1;
          tcyc = n;
          tcause = trap_cause_o;
          tpc = retire_pc_o;
          chk($sformatf("R9 v%0d ready low at trap", v), {31'd0, fetch_ready_o}, 32'd0);
          chk($sformatf("R6 v%0d vector", v), trap_vec_o, VEC);
        end
        if (fetch_valid_i && fetch_ready_o) issued++;
        @(negedge clk);
      end
      fetch_valid_i = 1'b0;
      irq_i = 1'b0;
      fault_i = '0;
      #1;
      chk($sformatf("R3 R5 v%0d trap cycle", v), 32'(tcyc), 32'(cv.trap_cy));
      chk($sformatf("R3 R4 v%0d trap cause", v), {29'd0, tcause}, {29'd0, cv.cause});
      chk($sformatf("R7 v%0d retire count", v), 32'(nret), 32'(cv.ret));
      chk($sformatf("R6 v%0d epc", v), epc_o, {16'd0, cv.epc});
      chk($sformatf("R6 v%0d saved cause", v), {29'd0, cause_o}, {29'd0, cv.cause});
      if (trapped) chk($sformatf("R8 v%0d trap pc", v), tpc, {16'd0, cv.epc});
    end

    // R10 directed: store gating around an execute-stage fault on instruction 1
    do_reset();
    for (int n = 0; n < 8; n++) begin
      fetch_valid_i = 1'b1;
      fetch_pc_i = BASE + 32'(4 * n);
      fault_i = (n == 4) ? 4'b0100 : 4'b0000;
      #1;
      if (n == 4) chk("R10 clean store allowed", {31'd0, mem_store_ok_o}, 32'd1);
      if (n == 5) chk("R10 faulted instr blocks store", {31'd0, mem_store_ok_o}, 32'd0);
      if (n == 6) chk("R10 trap blocks store", {31'd0, mem_store_ok_o}, 32'd0);
      if (n == 6) break;
      @(negedge clk);
    end

    // R10 directed: memory fault in the same cycle blocks the store
    do_reset();
    for (int n = 0; n < 5; n++) begin
      fetch_valid_i = 1'b1;
      fetch_pc_i = BASE + 32'(4 * n);
      fault_i = (n == 4) ? 4'b1000 : 4'b0000;
      #1;
      if (n == 4) chk("R10 mem fault blocks store", {31'd0, mem_store_ok_o}, 32'd0);
      @(negedge clk);
    end
    fetch_valid_i = 1'b0;
    fault_i = '0;

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule